// File: doc/BRIEF.md
# Clock Equation Sample Strobe Generator

This block makes the sample-enable strobe for synchronous (state) capture in a logic analyzer front end. It watches up to four external clock lines, which have already been brought into the internal clock domain and are sampled by a much faster internal clock. It raises a one-cycle `sample_en` pulse whenever the configured clock condition occurs. Data capture and storage are handled elsewhere. A capture path just qualifies its data register with `sample_en`.

There are two modes. In single-clock mode, only line 0 matters, and it fires on its rising edge, its falling edge, or both edges. In multi-clock mode, each line gets its own operand code: rising edge, falling edge, high level, low level, or excluded. All edge operands are OR-ed together, and all level operands are OR-ed together. The two groups are then AND-ed. An equation needs at least one edge operand. Without one, the configuration is flagged as invalid and never produces a strobe. When the source clock is sampled on both edges, it must run at no more than half the maximum strobe rate.

Top module: `ceq_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and on the cycle after any clock edge at which it was low, `sample_en` and `cfg_err` are 0.
- R2: The first line sample taken after reset release is only a reference. A line that is already high at release causes no rising-edge strobe.
- R3: In multi mode (`multi_mode`=1), the edge group is true when any line with code 1 (rise) went 0→1, or any line with code 2 (fall) went 1→0, between two consecutive samples. Lane i uses `op_sel[3*i+2:3*i]`.
- R4: In multi mode, lines with code 3 (high) or code 4 (low) form the level group. The group is true when any of these lines currently matches its level. The strobe requires both the edge group and the level group to be true.
- R5: In multi mode, when no lane has code 3 or code 4, the level group counts as true.
- R6: In multi mode, when no lane has code 1 or code 2, `cfg_err` is 1 and `sample_en` stays 0. `cfg_err` clears one cycle after a valid configuration is applied.
- R7: Code 0 and the reserved codes 5, 6 and 7 exclude a lane, so its line has no effect on the strobe.
- R8: In single mode (`multi_mode`=0), `edge_sel` selects the trigger on line 0: 0 for rising, 1 for falling, 2 for both edges. Lines 1 to 3 and `op_sel` are ignored.
- R9: In single mode, `edge_sel`=3 is reserved. It sets `cfg_err` and never strobes. In multi mode, `edge_sel` is ignored.
- R10: `sample_en` rises on the internal clock edge that follows the edge at which the changed line value was first sampled. It is high for exactly one cycle per qualifying change, and a line that holds its value causes no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_lines | input | NCH (4) | Synchronized external clock lines |
| multi_mode | input | 1 | 0 = single-clock mode on line 0, 1 = clock equation mode |
| op_sel | input | 3*NCH (12) | Per-lane operand code: 0 off, 1 rise, 2 fall, 3 high, 4 low, 5-7 off |
| edge_sel | input | 2 | Single-mode edge: 0 rise, 1 fall, 2 both, 3 reserved |
| sample_en | output | 1 | One-cycle sample-enable strobe |
| cfg_err | output | 1 | Current configuration cannot produce a strobe |

## Verification
The bench targets the operand grouping, using equations that mix edges and levels. Examples are an edge that meets a false level group, and a level-only change on a lane coded as a level. A design that OR-ed everything together, or AND-ed the edges, would pulse in the wrong places there.

Further cases cover the following:
- Lanes with reserved codes next to an edge lane. A decoder that treated reserved codes as levels would block the strobe.
- Level-only and all-excluded equations. A missing validity rule would either strobe or fail to raise the error.
- A line held high across reset release. A detector without a priming cycle would emit a spurious edge.
- Toggling line 0 on every cycle with both edges selected. This checks one pulse per change and no stretching.

// File: rtl/ceq_pkg.sv
`timescale 1ns/1ps
// Shared operand and edge-select encodings for the clock equation strobe logic.
package ceq_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_OFF  = 3'd0,
        OP_RISE = 3'd1,
        OP_FALL = 3'd2,
        OP_HIGH = 3'd3,
        OP_LOW  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SE_RISE = 2'd0,
        SE_FALL = 2'd1,
        SE_BOTH = 2'd2,
        SE_RSVD = 2'd3
    } sedge_e;
endpackage

// File: rtl/ceq_edge_detect.sv
`timescale 1ns/1ps
// Keeps the previous sample of every clock line and reports per-line rise and fall.
// Assumes the lines are already synchronized to clk. The "primed" output marks that
// a reference sample exists, so the first sample after reset makes no edge.
module ceq_edge_detect #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lines,
    output logic           primed,
    output logic [NCH-1:0] rise,
    output logic [NCH-1:0] fall
);
    logic [NCH-1:0] prev_q;

    // Store the reference sample and note that one has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            primed <= 1'b0;
        end else begin
            prev_q <= lines;
            primed <= 1'b1;
        end
    end

    // Compare the current and previous samples per line.
    always_comb begin
        rise = lines & ~prev_q;
        fall = ~lines & prev_q;
    end
endmodule

// File: rtl/ceq_operand_lane.sv
`timescale 1ns/1ps
// Decodes one lane's operand code into edge or level group membership and a hit.
// Codes outside the defined set exclude the lane.
module ceq_operand_lane
    import ceq_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           rise,
    input  logic           fall,
    input  logic           level,
    output logic           edge_en,
    output logic           edge_hit,
    output logic           lvl_en,
    output logic           lvl_hit
);
    // Map the code onto its group and evaluate the operand.
    always_comb begin
        edge_en  = 1'b0;
        edge_hit = 1'b0;
        lvl_en   = 1'b0;
        lvl_hit  = 1'b0;
        case (op)
            OP_RISE: begin edge_en = 1'b1; edge_hit = rise;   end
            OP_FALL: begin edge_en = 1'b1; edge_hit = fall;   end
            OP_HIGH: begin lvl_en  = 1'b1; lvl_hit  = level;  end
            OP_LOW:  begin lvl_en  = 1'b1; lvl_hit  = ~level; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ceq_equation.sv
`timescale 1ns/1ps
// Evaluates the multi-clock equation: OR of edge operands AND OR of level operands.
// The level group counts as true when it is empty. The equation is valid only with
// at least one edge operand.
module ceq_equation
    import ceq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [OPW*NCH-1:0] op_sel,
    input  logic [NCH-1:0]     lines,
    input  logic [NCH-1:0]     rise,
    input  logic [NCH-1:0]     fall,
    output logic               eq_hit,
    output logic               eq_valid
);
    logic [NCH-1:0] edge_en_v, edge_hit_v, lvl_en_v, lvl_hit_v;
    logic           edge_grp, lvl_grp;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        ceq_operand_lane u_lane (
            .op       (op_sel[OPW*i +: OPW]),
            .rise     (rise[i]),
            .fall     (fall[i]),
            .level    (lines[i]),
            .edge_en  (edge_en_v[i]),
            .edge_hit (edge_hit_v[i]),
            .lvl_en   (lvl_en_v[i]),
            .lvl_hit  (lvl_hit_v[i])
        );
    end

    // Combine the two groups under the grouping rules.
    always_comb begin
        edge_grp = |edge_hit_v;
        lvl_grp  = (|lvl_en_v) ? (|lvl_hit_v) : 1'b1;
        eq_valid = |edge_en_v;
        eq_hit   = eq_valid & edge_grp & lvl_grp;
    end
endmodule

// File: rtl/ceq_strobe_gen.sv
`timescale 1ns/1ps
// Top level: chooses between single-line edge triggering and the clock equation,
// then registers the strobe and the configuration error flag. Assumes clk_lines are
// synchronized and that configuration inputs are quasi-static.
module ceq_strobe_gen
    import ceq_pkg::*;
#(
    parameter int NCH = 4,
    localparam int OPB = OPW * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] clk_lines,
    input  logic           multi_mode,
    input  logic [OPB-1:0] op_sel,
    input  logic [1:0]     edge_sel,
    output logic           sample_en,
    output logic           cfg_err
);
    logic           primed;
    logic [NCH-1:0] rise, fall;
    logic           eq_hit, eq_valid;
    logic           one_hit, one_valid;
    logic           strobe_d, err_d;

    ceq_edge_detect #(.NCH(NCH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (clk_lines),
        .primed (primed),
        .rise   (rise),
        .fall   (fall)
    );

    ceq_equation #(.NCH(NCH)) u_eq (
        .op_sel   (op_sel),
        .lines    (clk_lines),
        .rise     (rise),
        .fall     (fall),
        .eq_hit   (eq_hit),
        .eq_valid (eq_valid)
    );

    // Single-clock mode trigger on line 0.
    always_comb begin
        one_valid = 1'b1;
        case (sedge_e'(edge_sel))
            SE_RISE: one_hit = rise[0];
            SE_FALL: one_hit = fall[0];
            SE_BOTH: one_hit = rise[0] | fall[0];
            default: begin one_hit = 1'b0; one_valid = 1'b0; end
        endcase
    end

    // Mode select and first-sample suppression.
    always_comb begin
        strobe_d = primed & (multi_mode ? eq_hit : one_hit);
        err_d    = multi_mode ? ~eq_valid : ~one_valid;
    end

    // Register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_en <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            sample_en <= strobe_d;
            cfg_err   <= err_d;
        end
    end
endmodule

// File: rtl/ceq_strobe_chk.sv
`timescale 1ns/1ps
// Property checker for ceq_strobe_gen, attached by bind.
module ceq_strobe_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   clk_lines,
    input logic             multi_mode,
    input logic [3*NCH-1:0] op_sel,
    input logic [1:0]       edge_sel,
    input logic             sample_en,
    input logic             cfg_err
);
    logic no_edge_op;

    // Check-side decode: does the equation lack any edge operand?
    always_comb begin
        no_edge_op = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (op_sel[3*i +: 3] == 3'd1 || op_sel[3*i +: 3] == 3'd2) no_edge_op = 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!sample_en && !cfg_err)); // R1
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_err && sample_en)); // R6
    AST_NO_EDGE_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_mode && no_edge_op) |=> cfg_err); // R6
    AST_STROBE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> ($past(clk_lines) != $past(clk_lines, 2))); // R10
    AST_SINGLE_LINE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_mode && $stable(clk_lines[0])) |=> !sample_en); // R8
endmodule

bind ceq_strobe_gen ceq_strobe_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_lines  (clk_lines),
    .multi_mode (multi_mode),
    .op_sel     (op_sel),
    .edge_sel   (edge_sel),
    .sample_en  (sample_en),
    .cfg_err    (cfg_err)
);

// File: tb/sim_ceq_strobe_gen.sv
`timescale 1ns/1ps
module sim_ceq_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lines = 4'b0001;
    logic        mm = 1'b0;
    logic [11:0] op = 12'd0;
    logic [1:0]  es = 2'd0;
    logic        sample_en, cfg_err;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ceq_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .clk_lines(lines), .multi_mode(mm),
        .op_sel(op), .edge_sel(es), .sample_en(sample_en), .cfg_err(cfg_err)
    );

    // {req, mode, op ch3, ch2, ch1, ch0, edge_sel, previous lines, current lines, strobe, err}
    localparam int NV = 24;
    localparam logic [28:0] VEC [NV] = '{
        {4'd3,1'b1,3'd2,3'd0,3'd1,3'd0,2'd0,4'b0000,4'b0010,1'b1,1'b0}, // R3 ch1 rise
        {4'd3,1'b1,3'd2,3'd0,3'd1,3'd0,2'd0,4'b1000,4'b0000,1'b1,1'b0}, // R3 ch3 fall
        {4'd3,1'b1,3'd2,3'd0,3'd1,3'd0,2'd0,4'b0010,4'b0000,1'b0,1'b0}, // R3 wrong direction
        {4'd3,1'b1,3'd2,3'd0,3'd1,3'd0,2'd0,4'b0000,4'b1000,1'b0,1'b0}, // R3 wrong direction
        {4'd4,1'b1,3'd2,3'd3,3'd1,3'd4,2'd0,4'b0100,4'b0110,1'b1,1'b0}, // R4 edge and low
        {4'd4,1'b1,3'd2,3'd3,3'd1,3'd4,2'd0,4'b0001,4'b0011,1'b0,1'b0}, // R4 level group false
        {4'd4,1'b1,3'd2,3'd3,3'd1,3'd4,2'd0,4'b0101,4'b0111,1'b1,1'b0}, // R4 edge and high
        {4'd4,1'b1,3'd2,3'd3,3'd1,3'd4,2'd0,4'b0000,4'b0101,1'b0,1'b0}, // R4 level lanes change only
        {4'd5,1'b1,3'd0,3'd0,3'd0,3'd1,2'd0,4'b0000,4'b0001,1'b1,1'b0}, // R5 no levels
        {4'd7,1'b1,3'd0,3'd0,3'd0,3'd1,2'd0,4'b1110,4'b1111,1'b1,1'b0}, // R7 off lanes ignored
        {4'd7,1'b1,3'd0,3'd7,3'd5,3'd1,2'd0,4'b0000,4'b0110,1'b0,1'b0}, // R7 reserved lanes no edge
        {4'd7,1'b1,3'd0,3'd6,3'd6,3'd1,2'd0,4'b0000,4'b0111,1'b1,1'b0}, // R7 reserved not levels
        {4'd6,1'b1,3'd0,3'd0,3'd4,3'd3,2'd0,4'b0000,4'b0001,1'b0,1'b1}, // R6 levels only
        {4'd6,1'b1,3'd0,3'd0,3'd0,3'd0,2'd0,4'b0000,4'b1111,1'b0,1'b1}, // R6 all off
        {4'd6,1'b1,3'd0,3'd0,3'd0,3'd6,2'd0,4'b0000,4'b0001,1'b0,1'b1}, // R6 reserved only
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd0,4'b0000,4'b0001,1'b1,1'b0}, // R8 rise
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd0,4'b0001,4'b0000,1'b0,1'b0}, // R8 rise ignores fall
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd1,4'b0001,4'b0000,1'b1,1'b0}, // R8 fall
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd1,4'b0000,4'b0001,1'b0,1'b0}, // R8 fall ignores rise
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd2,4'b0000,4'b0001,1'b1,1'b0}, // R8 both, rise
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd2,4'b0001,4'b0000,1'b1,1'b0}, // R8 both, fall
        {4'd8,1'b0,3'd0,3'd0,3'd0,3'd4,2'd2,4'b0000,4'b1110,1'b0,1'b0}, // R8 other lines ignored
        {4'd9,1'b0,3'd0,3'd0,3'd0,3'd4,2'd3,4'b0000,4'b0001,1'b0,1'b1}, // R9 reserved edge select
        {4'd9,1'b1,3'd0,3'd0,3'd0,3'd1,2'd3,4'b0000,4'b0001,1'b1,1'b0}  // R9 ignored in multi mode
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sample_en", sample_en, 1'b0);
        chk("R1 reset cfg_err", cfg_err, 1'b0);
        rst_n = 1'b1;                              // line 0 held high across release
        @(negedge clk); chk("R2 first sample no edge", sample_en, 1'b0);
        @(negedge clk); chk("R2 held line no edge", sample_en, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mm = VEC[i][24]; op = VEC[i][23:12]; es = VEC[i][11:10]; lines = VEC[i][9:6];
            @(negedge clk);
            lines = VEC[i][5:2];
            @(negedge clk);
            chk($sformatf("R%0d vec%0d sample_en", VEC[i][28:25], i), sample_en, VEC[i][1]);
            chk($sformatf("R%0d vec%0d cfg_err", VEC[i][28:25], i), cfg_err, VEC[i][0]);
        end

        // R10: one pulse per change, then back-to-back pulses when toggling each cycle
        mm = 1'b0; es = 2'd2; lines = 4'b0000;
        repeat (2) @(negedge clk);
        lines[0] = 1'b1;
        @(negedge clk); chk("R10 pulse after change", sample_en, 1'b1);
        @(negedge clk); chk("R10 pulse one cycle", sample_en, 1'b0);
        @(negedge clk); chk("R10 held line quiet", sample_en, 1'b0);
        for (int k = 0; k < 4; k++) begin
            lines[0] = ~lines[0];
            @(negedge clk); chk("R10 toggle each cycle", sample_en, 1'b1);
        end

        // R6: error clears one cycle after a valid equation
        mm = 1'b1; op = 12'd0;
        repeat (2) @(negedge clk); chk("R6 error raised", cfg_err, 1'b1);
        op = 12'd1;
        @(negedge clk); chk("R6 error cleared", cfg_err, 1'b0);

        // R1: reset in mid-run clears a raised error
        mm = 1'b0; es = 2'd3;
        repeat (2) @(negedge clk); chk("R9 error before reset", cfg_err, 1'b1);
        rst_n = 1'b0;
        @(negedge clk); chk("R1 mid-run reset cfg_err", cfg_err, 1'b0);
        chk("R1 mid-run reset sample_en", sample_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule